// File: doc/BRIEF.md
# Write Burst Scheduler for a Separate-I/O Low-Latency DRAM

This block sits on the controller side of a low-latency DRAM whose write data and read data use separate buses. Each write request carries a bank, an address, up to eight data words and one mask bit per word. Once a request is accepted, the block issues a WRITE command with the full bank and address in a single clock cycle. It then places the data on the dedicated double-data-rate input bus, using one rising-edge word and one falling-edge word per clock. The write latency is always one cycle longer than the programmed read latency.

Future data cycles are tracked in a timeline of slots, so bursts with different latencies can be in flight together. A request is held off only when its data window would land on cycles already claimed by an earlier burst. Because no read data path shares these wires, nothing here reserves turnaround cycles, and a read can be issued straight after a write by other logic.

Top module: `wr_burst_sched`

## Requirements
- R1: When a request is accepted (req_valid and req_ready high at a rising clock edge), the next cycle shows a WRITE: cs_n=0, we_n=0, ref_n=1. cmd_bank and cmd_addr carry that request's bank and address in the same cycle.
- R2: In every cycle that is not a WRITE, cs_n=1, we_n=1 and ref_n=1, and cmd_bank and cmd_addr are zero.
- R3: The read-latency code cfg_rl selects RL = cfg_rl+1 for codes 2 to 7. Codes 0 and 1 select RL = 3. The write latency is WL = RL+1. The first data cycle comes WL cycles after the WRITE command cycle.
- R4: The burst code cfg_bl gives 2 words over 1 cycle for code 0, 4 words over 2 cycles for code 1, and 8 words over 4 cycles for codes 2 and 3. Data cycles follow one another without gaps. In data cycle k, dq_rise carries word 2k and dq_fall carries word 2k+1. Word b is taken from req_data[b*DATA_W +: DATA_W].
- R5: In data cycle k, dm_rise equals req_mask[2k] and dm_fall equals req_mask[2k+1]. Both appear in the same cycle as their words, and a high bit marks a masked word.
- R6: dq_valid is high only in data cycles. In all other cycles, dq_rise, dq_fall, dm_rise and dm_fall are zero.
- R7: req_ready is low exactly when one of the new request's data cycles would coincide with a data cycle already scheduled. A request presented while req_ready is low produces no command and no data.
- R8: A request may be accepted while earlier bursts are still waiting out their latency. With 2-word bursts at a fixed latency, a request is accepted on every cycle.
- R9: The reset rst is synchronous and active high. While rst is high, req_ready is low. After a reset edge the command outputs are idle, the data outputs are zero, and any pending burst is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_rl | input | 3 | Read-latency code |
| cfg_bl | input | 2 | Burst-length code |
| req_valid | input | 1 | Write request valid |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_bank | input | BANK_W | Request bank |
| req_addr | input | ADDR_W | Request address |
| req_data | input | 8*DATA_W | Burst words, word 0 in the low bits |
| req_mask | input | 8 | Per-word mask, bit b for word b |
| cs_n | output | 1 | Chip select, active low |
| we_n | output | 1 | Write enable, active low |
| ref_n | output | 1 | Refresh, active low (held high) |
| cmd_bank | output | BANK_W | Command bank |
| cmd_addr | output | ADDR_W | Command address |
| dq_rise | output | DATA_W | Word for the rising data edge |
| dq_fall | output | DATA_W | Word for the falling data edge |
| dm_rise | output | 1 | Mask for the rising-edge word |
| dm_fall | output | 1 | Mask for the falling-edge word |
| dq_valid | output | 1 | Data cycle strobe |

## Verification
Within one cycle, the block can emit the WRITE command for a new request while data words of an earlier burst are leaving on the data bus. A late, short-latency request can also be slotted in ahead of the data of an earlier long-latency one. The bench provokes both cases with back-to-back requests and latency codes that change between requests, including a pair whose windows just collide. A behavioural timeline in the bench, indexed by absolute cycle number, predicts ready, the command and every data, mask and valid value, and these are compared each cycle.

// File: rtl/wbs_pkg.sv
package wbs_pkg;
  localparam int RL_W    = 3;
  localparam int BL_W    = 2;
  localparam int WL_W    = 4;
  localparam int NC_W    = 3;
  localparam int MAX_CYC = 4;                 // data cycles of the longest burst
  localparam int MAX_WL  = (1 << RL_W) + 1;   // longest write latency
  localparam int SLOTS   = MAX_WL + MAX_CYC;  // timeline length

  typedef enum logic [BL_W-1:0] {
    BURST_2  = 2'd0,
    BURST_4  = 2'd1,
    BURST_8  = 2'd2,
    BURST_8B = 2'd3
  } burst_code_e;
endpackage

// File: rtl/wbs_cfg_decode.sv
module wbs_cfg_decode
  import wbs_pkg::*;
(
  input  logic [RL_W-1:0] rl_code,
  input  logic [BL_W-1:0] bl_code,
  output logic [WL_W-1:0] wl,
  output logic [NC_W-1:0] ncyc
);
  always_comb begin
    // write latency = read latency + 1; low codes fall back to RL 3
    if (rl_code < 3'd2) wl = 4'd4;
    else                wl = {1'b0, rl_code} + 4'd2;

    case (burst_code_e'(bl_code))
      BURST_2: ncyc = 3'd1;
      BURST_4: ncyc = 3'd2;
      default: ncyc = 3'd4;
    endcase
  end
endmodule

// File: rtl/wbs_cmd_out.sv
module wbs_cmd_out #(
  parameter int BANK_W = 3,
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fire,
  input  logic [BANK_W-1:0] bank_in,
  input  logic [ADDR_W-1:0] addr_in,
  output logic              cs_n,
  output logic              we_n,
  output logic              ref_n,
  output logic [BANK_W-1:0] bank_out,
  output logic [ADDR_W-1:0] addr_out
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cs_n     <= 1'b1;
      we_n     <= 1'b1;
      ref_n    <= 1'b1;
      bank_out <= '0;
      addr_out <= '0;
    end else begin
      cs_n     <= !fire;
      we_n     <= !fire;
      ref_n    <= 1'b1;
      bank_out <= fire ? bank_in : '0;
      addr_out <= fire ? addr_in : '0;
    end
  end
endmodule

// File: rtl/wbs_slot_pipe.sv
module wbs_slot_pipe
  import wbs_pkg::*;
#(
  parameter int DATA_W = 9
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        load,
  input  logic [WL_W-1:0]             wl,
  input  logic [NC_W-1:0]             ncyc,
  input  logic [2*MAX_CYC*DATA_W-1:0] words,
  input  logic [2*MAX_CYC-1:0]        masks,
  output logic                        win_free,
  output logic [DATA_W-1:0]           dq_rise,
  output logic [DATA_W-1:0]           dq_fall,
  output logic                        dm_rise,
  output logic                        dm_fall,
  output logic                        dq_valid
);
  localparam int PW = 2*DATA_W + 2;   // {mask fall, mask rise, word fall, word rise}

  logic [SLOTS-1:0] occ;
  logic [SLOTS-1:0] occ_nx;
  logic [PW-1:0]    pay    [SLOTS];
  logic [PW-1:0]    pay_nx [SLOTS];

  // admission: slot wl+k moves to wl-1+k on the coming edge
  always_comb begin
    win_free = 1'b1;
    for (int k = 0; k < MAX_CYC; k++) begin
      if (k < int'(ncyc) && occ[int'(wl) + k]) win_free = 1'b0;
    end
  end

  always_comb begin
    for (int i = 0; i < SLOTS-1; i++) begin
      occ_nx[i] = occ[i+1];
      pay_nx[i] = pay[i+1];
    end
    occ_nx[SLOTS-1] = 1'b0;
    pay_nx[SLOTS-1] = '0;
    if (load) begin
      for (int k = 0; k < MAX_CYC; k++) begin
        if (k < int'(ncyc)) begin
          occ_nx[int'(wl) - 1 + k] = 1'b1;
          pay_nx[int'(wl) - 1 + k] = {masks[2*k+1], masks[2*k],
                                      words[(2*k+1)*DATA_W +: DATA_W],
                                      words[(2*k)*DATA_W +: DATA_W]};
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      occ <= '0;
      for (int i = 0; i < SLOTS; i++) pay[i] <= '0;
    end else begin
      occ <= occ_nx;
      for (int i = 0; i < SLOTS; i++) pay[i] <= pay_nx[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !occ[0]) begin
      dq_valid <= 1'b0;
      dq_rise  <= '0;
      dq_fall  <= '0;
      dm_rise  <= 1'b0;
      dm_fall  <= 1'b0;
    end else begin
      dq_valid <= 1'b1;
      dq_rise  <= pay[0][DATA_W-1:0];
      dq_fall  <= pay[0][2*DATA_W-1:DATA_W];
      dm_rise  <= pay[0][2*DATA_W];
      dm_fall  <= pay[0][2*DATA_W+1];
    end
  end
endmodule

// File: rtl/wr_burst_sched.sv
module wr_burst_sched
  import wbs_pkg::*;
#(
  parameter int DATA_W = 9,
  parameter int BANK_W = 3,
  parameter int ADDR_W = 20
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [RL_W-1:0]             cfg_rl,
  input  logic [BL_W-1:0]             cfg_bl,
  input  logic                        req_valid,
  output logic                        req_ready,
  input  logic [BANK_W-1:0]           req_bank,
  input  logic [ADDR_W-1:0]           req_addr,
  input  logic [2*MAX_CYC*DATA_W-1:0] req_data,
  input  logic [2*MAX_CYC-1:0]        req_mask,
  output logic                        cs_n,
  output logic                        we_n,
  output logic                        ref_n,
  output logic [BANK_W-1:0]           cmd_bank,
  output logic [ADDR_W-1:0]           cmd_addr,
  output logic [DATA_W-1:0]           dq_rise,
  output logic [DATA_W-1:0]           dq_fall,
  output logic                        dm_rise,
  output logic                        dm_fall,
  output logic                        dq_valid
);
  logic [WL_W-1:0] wl;
  logic [NC_W-1:0] ncyc;
  logic            win_free;
  logic            fire;

  wbs_cfg_decode u_dec (
    .rl_code (cfg_rl),
    .bl_code (cfg_bl),
    .wl      (wl),
    .ncyc    (ncyc)
  );

  assign req_ready = !rst && win_free;
  assign fire      = req_valid && req_ready;

  wbs_slot_pipe #(.DATA_W(DATA_W)) u_pipe (
    .clk      (clk),
    .rst      (rst),
    .load     (fire),
    .wl       (wl),
    .ncyc     (ncyc),
    .words    (req_data),
    .masks    (req_mask),
    .win_free (win_free),
    .dq_rise  (dq_rise),
    .dq_fall  (dq_fall),
    .dm_rise  (dm_rise),
    .dm_fall  (dm_fall),
    .dq_valid (dq_valid)
  );

  wbs_cmd_out #(.BANK_W(BANK_W), .ADDR_W(ADDR_W)) u_cmd (
    .clk      (clk),
    .rst      (rst),
    .fire     (fire),
    .bank_in  (req_bank),
    .addr_in  (req_addr),
    .cs_n     (cs_n),
    .we_n     (we_n),
    .ref_n    (ref_n),
    .bank_out (cmd_bank),
    .addr_out (cmd_addr)
  );
endmodule

// File: rtl/wbs_checker.sv
module wbs_checker
  import wbs_pkg::*;
#(
  parameter int DATA_W = 9,
  parameter int BANK_W = 3,
  parameter int ADDR_W = 20
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic              cs_n,
  input logic              we_n,
  input logic              ref_n,
  input logic [BANK_W-1:0] cmd_bank,
  input logic [ADDR_W-1:0] cmd_addr,
  input logic [DATA_W-1:0] dq_rise,
  input logic [DATA_W-1:0] dq_fall,
  input logic              dm_rise,
  input logic              dm_fall,
  input logic              dq_valid
);
  localparam int CW = $clog2(SLOTS + 2) + 1;
  localparam logic [CW-1:0] CMAX = '1;

  logic [CW-1:0] since_cmd;

  always_ff @(posedge clk) begin
    if (rst)               since_cmd <= CMAX;
    else if (!cs_n)        since_cmd <= CW'(1);
    else if (since_cmd != CMAX) since_cmd <= since_cmd + CW'(1);
  end

  assert_write_code_R1: assert property (@(posedge clk) disable iff (rst)
    !cs_n |-> (!we_n && ref_n));

  assert_cmd_after_accept_R1: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !cs_n);

  assert_cmd_needs_accept_R7: assert property (@(posedge clk) disable iff (rst)
    !cs_n |-> $past(req_valid && req_ready));

  assert_idle_cmd_R2: assert property (@(posedge clk) disable iff (rst)
    cs_n |-> (we_n && ref_n && cmd_bank == '0 && cmd_addr == '0));

  assert_quiet_data_R6: assert property (@(posedge clk) disable iff (rst)
    !dq_valid |-> (dq_rise == '0 && dq_fall == '0 && !dm_rise && !dm_fall));

  assert_data_window_R3: assert property (@(posedge clk) disable iff (rst)
    dq_valid |-> (since_cmd <= CW'(SLOTS)));

  assert_reset_hold_R9: assert property (@(posedge clk)
    rst |-> !req_ready);
endmodule

bind wr_burst_sched wbs_checker #(
  .DATA_W(DATA_W), .BANK_W(BANK_W), .ADDR_W(ADDR_W)
) u_wbs_chk (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .cs_n      (cs_n),
  .we_n      (we_n),
  .ref_n     (ref_n),
  .cmd_bank  (cmd_bank),
  .cmd_addr  (cmd_addr),
  .dq_rise   (dq_rise),
  .dq_fall   (dq_fall),
  .dm_rise   (dm_rise),
  .dm_fall   (dm_fall),
  .dq_valid  (dq_valid)
);

// File: tb/wr_burst_sched_test.sv
module wr_burst_sched_test;
  localparam int DW = 9;
  localparam int BW = 3;
  localparam int AW = 20;

  logic          clk = 1'b0;
  logic          rst;
  logic [2:0]    cfg_rl;
  logic [1:0]    cfg_bl;
  logic          req_valid;
  logic          req_ready;
  logic [BW-1:0] req_bank;
  logic [AW-1:0] req_addr;
  logic [8*DW-1:0] req_data;
  logic [7:0]    req_mask;
  logic          cs_n, we_n, ref_n;
  logic [BW-1:0] cmd_bank;
  logic [AW-1:0] cmd_addr;
  logic [DW-1:0] dq_rise, dq_fall;
  logic          dm_rise, dm_fall, dq_valid;

  always #4 clk = !clk;   // 125 MHz

  wr_burst_sched #(.DATA_W(DW), .BANK_W(BW), .ADDR_W(AW)) uut (
    .clk(clk), .rst(rst), .cfg_rl(cfg_rl), .cfg_bl(cfg_bl),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_bank(req_bank), .req_addr(req_addr),
    .req_data(req_data), .req_mask(req_mask),
    .cs_n(cs_n), .we_n(we_n), .ref_n(ref_n),
    .cmd_bank(cmd_bank), .cmd_addr(cmd_addr),
    .dq_rise(dq_rise), .dq_fall(dq_fall),
    .dm_rise(dm_rise), .dm_fall(dm_fall), .dq_valid(dq_valid)
  );

  int checks = 0;
  int errors = 0;
  int e = 0;          // rising edges seen
  int accepts = 0;
  bit last_rst = 1'b1;

  // expected timeline, indexed by edge number modulo 256
  bit            x_cmd [256];
  logic [BW-1:0] x_bank[256];
  logic [AW-1:0] x_addr[256];
  bit            x_dv  [256];
  logic [DW-1:0] x_dr  [256];
  logic [DW-1:0] x_df  [256];
  bit            x_mr  [256];
  bit            x_mf  [256];

  function automatic int model_wl(input logic [2:0] code);
    int rl;
    rl = (code <= 3'd1) ? 3 : int'(code) + 1;
    return rl + 1;
  endfunction

  function automatic int model_nc(input logic [1:0] code);
    if (code == 2'd0) return 1;
    if (code == 2'd1) return 2;
    return 4;
  endfunction

  task automatic clear_slot(input int idx);
    x_cmd[idx] = 0; x_bank[idx] = '0; x_addr[idx] = '0;
    x_dv[idx] = 0; x_dr[idx] = '0; x_df[idx] = '0; x_mr[idx] = 0; x_mf[idx] = 0;
  endtask

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at edge %0d: actual=%0h expected=%0h", tag, e, act, exp);
    end
  endtask

  task automatic step(input bit v, input logic [2:0] rl, input logic [1:0] bl,
                      input logic [BW-1:0] bk, input logic [AW-1:0] ad,
                      input logic [8*DW-1:0] d, input logic [7:0] m, input bit r);
    bit pred;
    int wl, nc, idx;
    rst = r; req_valid = v; cfg_rl = rl; cfg_bl = bl;
    req_bank = bk; req_addr = ad; req_data = d; req_mask = m;
    wl = model_wl(rl);
    nc = model_nc(bl);
    pred = !r;
    for (int k = 0; k < nc; k++) if (x_dv[(e + 1 + wl + k) & 255]) pred = 0;
    #1;
    chk(r ? "R9 ready during reset" : "R7 ready", 64'(req_ready), 64'(pred));
    @(posedge clk);
    if (r) begin
      for (int i = 0; i < 256; i++) clear_slot(i);
    end else if (v && pred) begin
      accepts++;
      idx = (e + 1) & 255;
      x_cmd[idx] = 1; x_bank[idx] = bk; x_addr[idx] = ad;
      for (int k = 0; k < nc; k++) begin
        idx = (e + 1 + wl + k) & 255;
        x_dv[idx] = 1;
        x_dr[idx] = d[(2*k)*DW +: DW];
        x_df[idx] = d[(2*k+1)*DW +: DW];
        x_mr[idx] = m[2*k];
        x_mf[idx] = m[2*k+1];
      end
    end
    @(negedge clk);
    e++;
    idx = e & 255;
    if (r) begin
      chk("R9 cs_n after reset", 64'(cs_n), 64'(1));
      chk("R9 dq_valid after reset", 64'(dq_valid), 64'(0));
    end else begin
      if (x_cmd[idx]) begin
        chk("R1 cs_n", 64'(cs_n), 64'(0));
        chk("R1 we_n", 64'(we_n), 64'(0));
        chk("R1 ref_n", 64'(ref_n), 64'(1));
        chk("R1 bank", 64'(cmd_bank), 64'(x_bank[idx]));
        chk("R1 addr", 64'(cmd_addr), 64'(x_addr[idx]));
      end else begin
        chk("R2 idle cmd", {cs_n, we_n, ref_n, cmd_bank, cmd_addr},
            {1'b1, 1'b1, 1'b1, {BW{1'b0}}, {AW{1'b0}}});
      end
      chk("R3 R6 dq_valid", 64'(dq_valid), 64'(x_dv[idx]));
      chk(last_rst ? "R9 dq_rise" : "R4 dq_rise", 64'(dq_rise), 64'(x_dr[idx]));
      chk("R4 dq_fall", 64'(dq_fall), 64'(x_df[idx]));
      chk("R5 dm_rise", 64'(dm_rise), 64'(x_mr[idx]));
      chk("R5 dm_fall", 64'(dm_fall), 64'(x_mf[idx]));
    end
    clear_slot(idx);
    last_rst = r;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 3'd2, 2'd0, '0, '0, '0, '0, 0);
  endtask

  function automatic logic [8*DW-1:0] pattern(input int seed);
    logic [8*DW-1:0] p;
    for (int b = 0; b < 8; b++) p[b*DW +: DW] = DW'(seed * 37 + b * 11 + 5);
    return p;
  endfunction

  initial begin
    int a0;
    rst = 1'b1; req_valid = 0; cfg_rl = '0; cfg_bl = '0;
    req_bank = '0; req_addr = '0; req_data = '0; req_mask = '0;
    for (int i = 0; i < 256; i++) clear_slot(i);
    @(negedge clk);
    // R9: reset holds everything idle
    for (int i = 0; i < 3; i++) step(1, 3'd5, 2'd2, 3'd1, 20'h1, '1, '1, 1);
    idle(2);
    // R3 R4: single bursts at several latencies and lengths, R5 masks
    step(1, 3'd2, 2'd0, 3'd3, 20'h12345, pattern(1), 8'h02, 0); idle(8);
    step(1, 3'd7, 2'd1, 3'd6, 20'hABCDE, pattern(2), 8'h05, 0); idle(14);
    step(1, 3'd0, 2'd2, 3'd0, 20'h00F0F, pattern(3), 8'hA5, 0); idle(10);
    step(1, 3'd1, 2'd3, 3'd7, 20'hFFFFF, pattern(4), 8'h3C, 0); idle(10);
    step(1, 3'd5, 2'd1, 3'd2, 20'h0C0C0, pattern(5), 8'h00, 0); idle(12);
    // R8: two-word bursts every cycle are all accepted
    a0 = accepts;
    for (int i = 0; i < 6; i++) step(1, 3'd4, 2'd0, BW'(i), AW'(i * 3), pattern(10 + i), 8'(i), 0);
    chk("R8 accepted back-to-back", 64'(accepts - a0), 64'(6));
    idle(10);
    // R7: eight-word bursts held valid, every fourth cycle accepted
    a0 = accepts;
    for (int i = 0; i < 8; i++) step(1, 3'd3, 2'd2, 3'd4, 20'h55, pattern(20 + i), 8'h81, 0);
    chk("R7 accepted under collision", 64'(accepts - a0), 64'(2));
    idle(14);
    // R8 R7: long latency then short latency slots in ahead, then a clash
    step(1, 3'd7, 2'd2, 3'd1, 20'h111, pattern(30), 8'h0F, 0);
    step(1, 3'd2, 2'd2, 3'd2, 20'h222, pattern(31), 8'hF0, 0);
    for (int i = 0; i < 6; i++) step(1, 3'd4, 2'd1, 3'd3, 20'h333, pattern(32), 8'h01, 0);
    idle(16);
    // mixed traffic
    for (int i = 0; i < 400; i++) begin
      bit v;
      v = ($urandom % 10) < 6;
      step(v, 3'($urandom), 2'($urandom), BW'($urandom), AW'($urandom),
           {$urandom, $urandom, $urandom}, 8'($urandom), 0);
    end
    idle(16);
    // R9: reset in the middle of a pending burst drops it
    step(1, 3'd6, 2'd2, 3'd5, 20'h777, pattern(40), 8'h00, 0);
    idle(3);
    step(0, 3'd6, 2'd2, '0, '0, '0, '0, 1);
    idle(16);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired at edge %0d", e);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule